// File: doc/BRIEF.md
# Reverse Channel Transmit Control Interface

This block is the host-facing side of a radio data modem's transmit path. A host writes bytes over a simple write bus with four addresses. The addresses hold the outgoing data byte, a host colour code, the transmit control bits and the receive/power control bits. The block keeps one outgoing byte in a holding register. It raises a data request whenever that register is empty and transmission is allowed. It flags an overrun when the host writes into a full holding register.

The start, end-of-frame and end-of-sequence control bits become one-cycle strobes. A start request waits until the downstream path reports a free slot, and then launches the transmission. At launch the block latches the colour code for the first block. That code is either the host value or the code last received on the receive channel. Frame lengths are checked at each end-of-frame. A two-step soft reset clears every write register. A zero-power control drops a ready output, which comes back only after a programmable oscillator settle time. A slot-available input and a byte-consume input stand in for the downstream datapath.

Top module: `tx_ctl_regbank`

## Requirements
- R1: After `rst_n` low, `tx_en`, `rx_en`, `tx_req`, `tx_byte_valid`, `ready`, `len_err` and `ovr_err` are 0, while `tx_powersave` and `zero_power` are 1.
- R2: A write to address 0 stores `wr_data` (bit 7 is the MSB) in the holding register. From the next cycle it appears on `tx_byte`, with `tx_byte_valid` high. A `byte_take` pulse while valid empties the register.
- R3: `tx_req` is high exactly when the holding register is empty, `tx_en` is 1 and `ready` is 1. It is low in the cycle after any write to address 0.
- R4: A write to address 0 while the holding register is full, with no `byte_take` in that cycle, drops the new byte, leaves `tx_byte` unchanged and sets `ovr_err`. `ovr_err` stays set until a soft reset.
- R5: At address 2, bit 0 is the stored transmit enable, with `tx_powersave` as its inverse, and bit 4 is the stored colour-code force. Bits 7:5 have no effect.
- R6: Writing address 2 with bit 1, bit 2 or bit 3 set pulses `start_pulse`, `eof_pulse` or `eos_pulse` respectively, for exactly the one cycle after the write.
- R7: A start write whose bit 0 is also 1 arms a launch. `tx_go` pulses for one cycle after the first clock on which `slot_avail`, `tx_en` and `ready` are all high. It does not fire if the transmit enable is 0.
- R8: On `tx_go`, `cc_out` takes the host colour code written at address 1 if the force bit (address 2, bit 4) is 1. Otherwise it takes the `rx_cc` input.
- R9: An end-of-frame write that follows fewer than MIN_FRAME (2) or more than MAX_FRAME (136) data writes since the previous end-of-frame sets the sticky `len_err`. Each end-of-frame clears the count.
- R10: At address 3, bit 3 drives `rx_en`, bits 2:0 drive `sync_limit`, and bit 4 at 0 selects zero power (`zero_power` = 1).
- R11: `ready` is low while in zero power and in the cycle after a zero-power write. After a write that leaves zero power, `ready` rises OSC_SETTLE cycles later. Writes that keep power on do not restart the count.
- R12: Writing address 3 with bit 7 = 1 and later with bit 7 = 0 clears every write register, the holding register, the count and both sticky errors, and pulses `soft_rst` for one cycle. The arming write alone clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DW | Write data |
| rx_cc | input | DW | Colour code last captured from the receive channel |
| slot_avail | input | 1 | Downstream transmit slot is free |
| byte_take | input | 1 | Downstream consumes the held byte |
| tx_req | output | 1 | Data request: holding register can take a byte |
| tx_byte | output | DW | Held data byte |
| tx_byte_valid | output | 1 | Holding register full |
| start_pulse | output | 1 | Start strobe |
| eof_pulse | output | 1 | End-of-frame strobe |
| eos_pulse | output | 1 | End-of-sequence strobe |
| tx_go | output | 1 | Transmission launched |
| cc_out | output | DW | Colour code for the first block |
| tx_en | output | 1 | Transmit enabled |
| tx_powersave | output | 1 | Transmit path in powersave |
| rx_en | output | 1 | Receive enabled |
| sync_limit | output | 3 | Sync word error limit |
| zero_power | output | 1 | Device in zero power |
| ready | output | 1 | Powered and oscillator settled |
| soft_rst | output | 1 | Soft reset happened |
| len_err | output | 1 | Sticky frame-length error |
| ovr_err | output | 1 | Sticky holding-register overrun |

## Verification
Frame lengths of 1, 2, 136 and 137 bytes are sent. They separate a correct range check from an off-by-one at either bound. The 136-byte frame follows a 2-byte one, which also shows that the count clears. Launches are driven with the force bit set and clear, using distinct host and receive codes, to catch a swapped colour-code mux. A start issued with the enable clear shows the launch gating. A second write into a full register with no consume separates overrun from normal loading. The arming write is checked on its own before the completing write, to show the reset needs both.

// File: rtl/txc_pkg.sv
package txc_pkg;
   typedef enum logic [1:0] {
      A_DATA = 2'd0,
      A_HCC  = 2'd1,
      A_TCTL = 2'd2,
      A_RCTL = 2'd3
   } txc_addr_e;

   // transmit control bit positions
   localparam int B_TXEN  = 0;
   localparam int B_START = 1;
   localparam int B_EOF   = 2;
   localparam int B_EOS   = 3;
   localparam int B_FORCE = 4;
   // receive / power control bit positions
   localparam int B_RXEN  = 3;
   localparam int B_PWR   = 4;
   localparam int B_SRST  = 7;
   localparam int LIM_W   = 3;
endpackage

// File: rtl/txc_regs.sv
module txc_regs
   import txc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    host_cc,
   output logic             force_cc,
   output logic             tx_en,
   output logic             rx_en,
   output logic [LIM_W-1:0] sync_limit,
   output logic             pwr_on,
   output logic             start_p,
   output logic             eof_p,
   output logic             eos_p,
   output logic             soft_rst,
   output logic             srst,
   output logic             pwr_up,
   output logic             start_req,
   output logic             eof_req,
   output logic             data_wr
);
   txc_addr_e addr;
   logic      hit_hcc, hit_tctl, hit_rctl;
   logic      armed;

   assign addr = txc_addr_e'(wr_addr);

   always_comb begin
      data_wr   = wr_en && (addr == A_DATA);
      hit_hcc   = wr_en && (addr == A_HCC);
      hit_tctl  = wr_en && (addr == A_TCTL);
      hit_rctl  = wr_en && (addr == A_RCTL);
      srst      = hit_rctl && !wr_data[B_SRST] && armed;
      pwr_up    = hit_rctl && wr_data[B_PWR] && !pwr_on && !srst;
      start_req = hit_tctl && wr_data[B_START] && wr_data[B_TXEN];
      eof_req   = hit_tctl && wr_data[B_EOF];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_cc    <= '0;
         force_cc   <= 1'b0;
         tx_en      <= 1'b0;
         rx_en      <= 1'b0;
         sync_limit <= '0;
         pwr_on     <= 1'b0;
         armed      <= 1'b0;
         start_p    <= 1'b0;
         eof_p      <= 1'b0;
         eos_p      <= 1'b0;
         soft_rst   <= 1'b0;
      end else begin
         start_p  <= 1'b0;
         eof_p    <= 1'b0;
         eos_p    <= 1'b0;
         soft_rst <= 1'b0;
         if (srst) begin
            host_cc    <= '0;
            force_cc   <= 1'b0;
            tx_en      <= 1'b0;
            rx_en      <= 1'b0;
            sync_limit <= '0;
            pwr_on     <= 1'b0;
            armed      <= 1'b0;
            soft_rst   <= 1'b1;
         end else begin
            if (hit_hcc) host_cc <= wr_data;
            if (hit_tctl) begin
               force_cc <= wr_data[B_FORCE];
               tx_en    <= wr_data[B_TXEN];
               start_p  <= wr_data[B_START];
               eof_p    <= wr_data[B_EOF];
               eos_p    <= wr_data[B_EOS];
            end
            if (hit_rctl) begin
               armed      <= wr_data[B_SRST];
               pwr_on     <= wr_data[B_PWR];
               rx_en      <= wr_data[B_RXEN];
               sync_limit <= wr_data[LIM_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/txc_holding.sv
module txc_holding #(
   parameter int DW        = 8,
   parameter int MIN_FRAME = 2,
   parameter int MAX_FRAME = 136
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          data_wr,
   input  logic [DW-1:0] wr_data,
   input  logic          eof_req,
   input  logic          byte_take,
   input  logic          req_ok,
   output logic [DW-1:0] tx_byte,
   output logic          full,
   output logic          tx_req,
   output logic          len_err,
   output logic          ovr_err
);
   localparam int CW = $clog2(MAX_FRAME + 2);
   localparam logic [CW-1:0] MINV = CW'(MIN_FRAME);
   localparam logic [CW-1:0] MAXV = CW'(MAX_FRAME);
   localparam logic [CW-1:0] SATV = CW'(MAX_FRAME + 1);

   logic [CW-1:0] cnt;
   logic          take;

   assign take   = byte_take && full;
   assign tx_req = req_ok && !full;

   always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
         tx_byte <= '0;
         full    <= 1'b0;
         cnt     <= '0;
         len_err <= 1'b0;
         ovr_err <= 1'b0;
      end else begin
         if (data_wr) begin
            if (full && !take) begin
               ovr_err <= 1'b1;
            end else begin
               tx_byte <= wr_data;
               full    <= 1'b1;
               if (cnt != SATV) cnt <= cnt + 1'b1;
            end
         end else if (take) begin
            full <= 1'b0;
         end
         if (eof_req) begin
            if ((cnt < MINV) || (cnt > MAXV)) len_err <= 1'b1;
            cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/txc_launch.sv
module txc_launch #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          start_req,
   input  logic          slot_avail,
   input  logic          tx_en,
   input  logic          ready,
   input  logic          force_cc,
   input  logic [DW-1:0] host_cc,
   input  logic [DW-1:0] rx_cc,
   output logic          tx_go,
   output logic [DW-1:0] cc_out
);
   logic pend;

   always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
         pend   <= 1'b0;
         tx_go  <= 1'b0;
         cc_out <= '0;
      end else begin
         tx_go <= 1'b0;
         if (start_req) begin
            pend <= 1'b1;
         end else if (!tx_en) begin
            pend <= 1'b0;
         end else if (pend && slot_avail && ready) begin
            pend   <= 1'b0;
            tx_go  <= 1'b1;
            cc_out <= force_cc ? host_cc : rx_cc;
         end
      end
   end
endmodule

// File: rtl/txc_power.sv
module txc_power #(
   parameter int OSC_SETTLE = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   input  logic pwr_up,
   output logic ready
);
   generate
      if (OSC_SETTLE == 0) begin : g_nowait
         assign ready = pwr_on;
      end else begin : g_wait
         localparam int SW = $clog2(OSC_SETTLE + 1);
         localparam logic [SW-1:0] LOADV = SW'(OSC_SETTLE);
         logic [SW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) cnt <= '0;
            else if (pwr_up) cnt <= LOADV;
            else if (cnt != '0) cnt <= cnt - 1'b1;
         end
         assign ready = pwr_on && (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/tx_ctl_regbank.sv
module tx_ctl_regbank #(
   parameter int DW         = 8,
   parameter int MIN_FRAME  = 2,
   parameter int MAX_FRAME  = 136,
   parameter int OSC_SETTLE = 4096
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] rx_cc,
   input  logic          slot_avail,
   input  logic          byte_take,
   output logic          tx_req,
   output logic [DW-1:0] tx_byte,
   output logic          tx_byte_valid,
   output logic          start_pulse,
   output logic          eof_pulse,
   output logic          eos_pulse,
   output logic          tx_go,
   output logic [DW-1:0] cc_out,
   output logic          tx_en,
   output logic          tx_powersave,
   output logic          rx_en,
   output logic [2:0]    sync_limit,
   output logic          zero_power,
   output logic          ready,
   output logic          soft_rst,
   output logic          len_err,
   output logic          ovr_err
);
   generate
      if (DW < 8) begin : g_bad_dw
         $error("DW must be at least 8");
      end
      if (MIN_FRAME < 1 || MAX_FRAME < MIN_FRAME) begin : g_bad_frame
         $error("frame bounds inconsistent");
      end
      if (OSC_SETTLE < 0) begin : g_bad_settle
         $error("OSC_SETTLE must not be negative");
      end
   endgenerate

   logic [DW-1:0] host_cc;
   logic          force_cc, pwr_on, srst, pwr_up, start_req, eof_req, data_wr;

   txc_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .host_cc(host_cc), .force_cc(force_cc), .tx_en(tx_en), .rx_en(rx_en),
      .sync_limit(sync_limit), .pwr_on(pwr_on), .start_p(start_pulse),
      .eof_p(eof_pulse), .eos_p(eos_pulse), .soft_rst(soft_rst), .srst(srst),
      .pwr_up(pwr_up), .start_req(start_req), .eof_req(eof_req), .data_wr(data_wr)
   );

   txc_power #(.OSC_SETTLE(OSC_SETTLE)) u_pwr (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .pwr_up(pwr_up), .ready(ready)
   );

   txc_holding #(.DW(DW), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)) u_hold (
      .clk(clk), .rst_n(rst_n), .srst(srst), .data_wr(data_wr), .wr_data(wr_data),
      .eof_req(eof_req), .byte_take(byte_take), .req_ok(tx_en && ready),
      .tx_byte(tx_byte), .full(tx_byte_valid), .tx_req(tx_req),
      .len_err(len_err), .ovr_err(ovr_err)
   );

   txc_launch #(.DW(DW)) u_launch (
      .clk(clk), .rst_n(rst_n), .srst(srst), .start_req(start_req),
      .slot_avail(slot_avail), .tx_en(tx_en), .ready(ready), .force_cc(force_cc),
      .host_cc(host_cc), .rx_cc(rx_cc), .tx_go(tx_go), .cc_out(cc_out)
   );

   assign tx_powersave = !tx_en;
   assign zero_power   = !pwr_on;
endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [1:0]    wr_addr,
   input logic [DW-1:0] wr_data,
   input logic [DW-1:0] rx_cc,
   input logic          slot_avail,
   input logic          byte_take,
   input logic          tx_req,
   input logic          tx_byte_valid,
   input logic          start_pulse,
   input logic          eof_pulse,
   input logic          tx_go,
   input logic [DW-1:0] cc_out,
   input logic          force_cc,
   input logic [DW-1:0] host_cc,
   input logic          tx_en,
   input logic          ready,
   input logic          ovr_err
);
   assert_data_wr_clears_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0) |=> !tx_req);

   assert_req_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (tx_en && ready && !tx_byte_valid));

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0 && tx_byte_valid && !byte_take) |=> ovr_err);

   assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_err && !(wr_en && wr_addr == 2'd3)) |=> ovr_err);

   assert_eof_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eof_pulse |-> $past(wr_en && wr_addr == 2'd2 && wr_data[2]));

   assert_start_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(wr_en && wr_addr == 2'd2 && wr_data[1]));

   assert_go_needs_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |-> ($past(slot_avail) && $past(tx_en) && $past(ready)));

   assert_cc_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_go && $past(force_cc)) |-> (cc_out == $past(host_cc)));

   assert_cc_received_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_go && !$past(force_cc)) |-> (cc_out == $past(rx_cc)));

   assert_zero_power_drops_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3 && !wr_data[4]) |=> !ready);
endmodule

bind tx_ctl_regbank txc_checker #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rx_cc(rx_cc), .slot_avail(slot_avail), .byte_take(byte_take), .tx_req(tx_req),
   .tx_byte_valid(tx_byte_valid), .start_pulse(start_pulse), .eof_pulse(eof_pulse),
   .tx_go(tx_go), .cc_out(cc_out), .force_cc(force_cc), .host_cc(host_cc),
   .tx_en(tx_en), .ready(ready), .ovr_err(ovr_err)
);

// File: tb/sim_tx_ctl_regbank.sv
module sim_tx_ctl_regbank;
   localparam int CLK_NS = 10;
   localparam int SETTLE = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rx_cc = 8'd0;
   logic       slot_avail = 1'b0;
   logic       byte_take = 1'b0;
   logic       tx_req, tx_byte_valid, start_pulse, eof_pulse, eos_pulse, tx_go;
   logic       tx_en, tx_powersave, rx_en, zero_power, ready, soft_rst, len_err, ovr_err;
   logic [7:0] tx_byte, cc_out;
   logic [2:0] sync_limit;

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_NS/2) clk = ~clk;

   tx_ctl_regbank #(.DW(8), .MIN_FRAME(2), .MAX_FRAME(136), .OSC_SETTLE(SETTLE)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rx_cc(rx_cc), .slot_avail(slot_avail), .byte_take(byte_take), .tx_req(tx_req),
      .tx_byte(tx_byte), .tx_byte_valid(tx_byte_valid), .start_pulse(start_pulse),
      .eof_pulse(eof_pulse), .eos_pulse(eos_pulse), .tx_go(tx_go), .cc_out(cc_out),
      .tx_en(tx_en), .tx_powersave(tx_powersave), .rx_en(rx_en), .sync_limit(sync_limit),
      .zero_power(zero_power), .ready(ready), .soft_rst(soft_rst), .len_err(len_err),
      .ovr_err(ovr_err)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic push(input logic [7:0] d);
      wr(2'd0, d);
      byte_take = 1'b1;
      @(negedge clk);
      byte_take = 1'b0;
   endtask

   task automatic power_up();
      wr(2'd3, 8'h10);
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic fresh();
      wr(2'd3, 8'h80);
      wr(2'd3, 8'h00);
      power_up();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "tx_en", tx_en, 0);
      chk("R1", "rx_en", rx_en, 0);
      chk("R1", "tx_powersave", tx_powersave, 1);
      chk("R1", "zero_power", zero_power, 1);
      chk("R1", "ready", ready, 0);
      chk("R1", "tx_req", tx_req, 0);
      chk("R1", "valid", tx_byte_valid, 0);
      chk("R1", "errors", {len_err, ovr_err}, 0);
   endtask

   task automatic t_power();
      wr(2'd3, 8'h10);
      chk("R10", "zero_power off", zero_power, 0);
      chk("R11", "ready right after power", ready, 0);
      repeat (SETTLE-1) @(negedge clk);
      chk("R11", "ready one short of settle", ready, 0);
      @(negedge clk);
      chk("R11", "ready at settle", ready, 1);
      wr(2'd3, 8'h1D);
      chk("R10", "rx_en", rx_en, 1);
      chk("R10", "sync_limit", sync_limit, 5);
      chk("R11", "no restart while powered", ready, 1);
      wr(2'd3, 8'h0A);
      chk("R10", "zero_power on", zero_power, 1);
      chk("R11", "ready dropped", ready, 0);
      chk("R10", "sync_limit 2", sync_limit, 2);
      power_up();
      chk("R11", "ready again", ready, 1);
   endtask

   task automatic t_data();
      wr(2'd2, 8'h01);
      chk("R5", "tx_en", tx_en, 1);
      chk("R5", "powersave", tx_powersave, 0);
      chk("R3", "req when empty", tx_req, 1);
      wr(2'd0, 8'h96);
      chk("R2", "tx_byte", tx_byte, 8'h96);
      chk("R2", "valid", tx_byte_valid, 1);
      chk("R3", "req after write", tx_req, 0);
      byte_take = 1'b1;
      @(negedge clk);
      byte_take = 1'b0;
      chk("R2", "emptied", tx_byte_valid, 0);
      chk("R3", "req after take", tx_req, 1);
   endtask

   task automatic t_overrun();
      wr(2'd0, 8'h11);
      wr(2'd0, 8'h22);
      chk("R4", "ovr_err", ovr_err, 1);
      chk("R4", "byte kept", tx_byte, 8'h11);
      byte_take = 1'b1;
      @(negedge clk);
      byte_take = 1'b0;
      @(negedge clk);
      chk("R4", "ovr sticky", ovr_err, 1);
   endtask

   task automatic t_softreset();
      wr(2'd3, 8'h90);
      chk("R12", "arm alone keeps ovr", ovr_err, 1);
      chk("R12", "arm alone no pulse", soft_rst, 0);
      chk("R12", "arm alone keeps tx_en", tx_en, 1);
      wr(2'd3, 8'h10);
      chk("R12", "soft_rst pulse", soft_rst, 1);
      chk("R12", "ovr cleared", ovr_err, 0);
      chk("R12", "tx_en cleared", tx_en, 0);
      chk("R12", "power cleared", zero_power, 1);
      chk("R12", "ready cleared", ready, 0);
      @(negedge clk);
      chk("R12", "soft_rst one cycle", soft_rst, 0);
      power_up();
   endtask

   task automatic t_ctrl();
      wr(2'd2, 8'hE1);
      chk("R5", "high bits ignored tx_en", tx_en, 1);
      chk("R5", "high bits no strobes", {start_pulse, eof_pulse, eos_pulse}, 0);
      wr(2'd2, 8'h0D);
      chk("R6", "eof+eos strobes", {start_pulse, eof_pulse, eos_pulse}, 3'b011);
      @(negedge clk);
      chk("R6", "strobes one cycle", {start_pulse, eof_pulse, eos_pulse}, 0);
      wr(2'd2, 8'h00);
      chk("R5", "disable", {tx_en, tx_powersave}, 2'b01);
      chk("R3", "no req disabled", tx_req, 0);
   endtask

   task automatic t_launch();
      rx_cc = 8'h3C;
      wr(2'd1, 8'hA5);
      wr(2'd2, 8'h13);
      chk("R6", "start strobe", start_pulse, 1);
      repeat (3) @(negedge clk);
      chk("R7", "no go without slot", tx_go, 0);
      slot_avail = 1'b1;
      @(negedge clk);
      chk("R7", "go on slot", tx_go, 1);
      chk("R8", "forced host code", cc_out, 8'hA5);
      @(negedge clk);
      chk("R7", "go single pulse", tx_go, 0);
      slot_avail = 1'b0;
      wr(2'd2, 8'h03);
      slot_avail = 1'b1;
      @(negedge clk);
      chk("R7", "second go", tx_go, 1);
      chk("R8", "received code", cc_out, 8'h3C);
      slot_avail = 1'b0;
      wr(2'd2, 8'h02);
      slot_avail = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7", "no go when disabled", tx_go, 0);
      slot_avail = 1'b0;
   endtask

   task automatic t_length();
      fresh();
      wr(2'd2, 8'h01);
      push(8'h01);
      wr(2'd2, 8'h05);
      chk("R9", "1-byte frame flagged", len_err, 1);
      fresh();
      wr(2'd2, 8'h01);
      for (int i = 0; i < 2; i++) push(8'(i));
      wr(2'd2, 8'h05);
      chk("R9", "2-byte frame ok", len_err, 0);
      for (int i = 0; i < 136; i++) push(8'(i));
      wr(2'd2, 8'h05);
      chk("R9", "136-byte frame ok after clear", len_err, 0);
      for (int i = 0; i < 137; i++) push(8'(i));
      wr(2'd2, 8'h05);
      chk("R9", "137-byte frame flagged", len_err, 1);
   endtask

   initial begin : watchdog
      #(CLK_NS * 150000);
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_power();
      t_data();
      t_overrun();
      t_softreset();
      t_ctrl();
      t_launch();
      t_length();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule